// File: doc/BRIEF.md
# Circular Complex-Vector Address Generator

This block produces the byte address used to fetch the elements of a complex vector from external memory. Each element is a pair of 16-bit words: the real part at a 4-byte-aligned address and the imaginary part two bytes above it. A pointer register holds the current address. After every 16-bit access, the pointer moves forward by one word.

Only a window of low address bits, chosen by a size code, takes part in the increment. When the window overflows, the pointer wraps to the start of its aligned buffer. The bits above the window never change. Size code k gives a buffer of 2^(k+2) bytes.

Software or a sequencer loads a start address. It then pulses the step input once per completed word access. The block reports three things:
- whether the current address points at a real part or an imaginary part;
- a one-cycle strobe whenever a whole element (real then imaginary) has been consumed;
- a flag when a loaded start address was not 4-byte aligned.

Top module: `cplx_ring_agen`

## Requirements
- R1: After reset, the address is 0, the imaginary-phase output is 0, the element strobe is 0 and the alignment flag is 0.
- R2: A load of an address whose bits [1:0] are 00 makes that address appear on the address output after the next clock edge and clears the alignment flag.
- R3: A load of an address whose bits [1:0] are not 00 stores it with bits [1:0] forced to 00 and sets the alignment flag. The address output bit 0 is never 1.
- R4: A step with no load advances the address by 2 bytes when that does not cross the end of the window.
- R5: A step from the last word of the window returns the low window bits to 0. Address bits at or above the window width keep their values on every step.
- R6: Size code k (a 4-bit value) sets the window to the low k+2 address bits, that is, a buffer of 2^(k+2) bytes. Codes 0, 1 and 3 give 4-, 8- and 32-byte buffers.
- R7: The imaginary-phase output equals address bit 1: 0 for the real word at base+4n and 1 for the imaginary word at base+4n+2. Every step toggles it.
- R8: The element strobe is high for exactly the one cycle after a step taken while the imaginary phase is 1. It is low after any other cycle.
- R9: When a load and a step occur in the same cycle, the load wins, and no element strobe follows.
- R10: With neither load nor step, the address holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Load the pointer from load_addr |
| load_addr | input | ADDR_W (32) | Start byte address |
| size_code | input | SIZE_W (4) | Buffer size code k; buffer is 2^(k+2) bytes |
| step | input | 1 | One 16-bit access has completed; advance the pointer |
| addr | output | ADDR_W (32) | Current byte address |
| imag_phase | output | 1 | 1 when addr points at an imaginary part |
| elem_done | output | 1 | One-cycle pulse after the imaginary word of an element is consumed |
| align_err | output | 1 | The last load was not 4-byte aligned |

## Verification
A load and a step can arrive in the same cycle. They compete for the pointer register, and the step would also raise the element strobe. The bench walks the pointer onto an imaginary word, then raises load_en and step together. It judges that the following cycle shows the aligned load address in the real phase, with the strobe low. Checker properties confirm that, on every step, the address bits above the window stay frozen for the size code in use.

// File: rtl/cra_pkg.sv
// Shared constants and types for the circular complex-vector address generator.
// Assumes byte addressing and 16-bit words, two words per complex element.
package cra_pkg;
    localparam int WORD_BYTES = 2;   // one real or imaginary word
    localparam int ELEM_BYTES = 4;   // one complex element
    localparam int ALIGN_BITS = 2;   // log2(ELEM_BYTES)

    typedef enum logic {
        PH_REAL = 1'b0,
        PH_IMAG = 1'b1
    } phase_e;
endpackage

// File: rtl/cra_mask_dec.sv
// Window mask decoder: turns the size code into a mask of the address bits
// that take part in the increment. Code k gives k+2 low bits set.
// Assumes the code is static while a step is in flight.
// If k+2 exceeds the address width, the mask is all ones.
module cra_mask_dec #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 4
) (
    input  logic [SIZE_W-1:0] size_code,
    output logic [ADDR_W-1:0] win_mask
);
    import cra_pkg::*;

    localparam int SPAN_W = SIZE_W + 1;

    logic [SPAN_W-1:0] span;

    // number of low bits in the window
    assign span = SPAN_W'(size_code) + SPAN_W'(ALIGN_BITS);

    // one comparator per address bit
    for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
        assign win_mask[g] = (32'(span) > 32'(g));
    end
endmodule

// File: rtl/cra_ptr_next.sv
// Masked incrementer: adds one word to the pointer inside the window bits
// and passes the bits above the window through unchanged.
// Assumes the mask is a run of ones starting at bit 0.
module cra_ptr_next #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_ptr,
    input  logic [ADDR_W-1:0] win_mask,
    output logic [ADDR_W-1:0] nxt_ptr
);
    import cra_pkg::*;

    logic [ADDR_W-1:0] bumped;

    // full-width add of one word
    assign bumped  = cur_ptr + ADDR_W'(WORD_BYTES);

    // keep the upper bits, take the window bits from the sum
    assign nxt_ptr = (cur_ptr & ~win_mask) | (bumped & win_mask);
endmodule

// File: rtl/cplx_ring_agen.sv
// Top of the circular complex-vector address generator.
// Holds the pointer register, handles loads (with forced alignment) and
// masked steps, and produces the phase and element-complete outputs.
// Assumes: a load takes priority over a step in the same cycle; the
// reset is synchronous and active low.
module cplx_ring_agen #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [SIZE_W-1:0] size_code,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              imag_phase,
    output logic              elem_done,
    output logic              align_err
);
    import cra_pkg::*;

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] win_mask;
    logic [ADDR_W-1:0] ptr_step;
    logic [ADDR_W-1:0] load_aligned;
    logic              do_step;
    phase_e            phase;

    cra_mask_dec #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_mask (
        .size_code (size_code),
        .win_mask  (win_mask)
    );

    cra_ptr_next #(.ADDR_W(ADDR_W)) u_next (
        .cur_ptr  (ptr_q),
        .win_mask (win_mask),
        .nxt_ptr  (ptr_step)
    );

    // load value with the element-offset bits cleared
    assign load_aligned = {load_addr[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    // a step counts only when no load competes
    assign do_step      = step && !load_en;
    // word phase comes from the word-select bit of the pointer
    assign phase        = phase_e'(ptr_q[1]);

    // pointer register: load has priority over step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load_en) begin
            ptr_q <= load_aligned;
        end else if (do_step) begin
            ptr_q <= ptr_step;
        end
    end

    // alignment flag follows the most recent load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            align_err <= 1'b0;
        end else if (load_en) begin
            align_err <= |load_addr[ALIGN_BITS-1:0];
        end
    end

    // element strobe after the imaginary word is consumed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elem_done <= 1'b0;
        end else begin
            elem_done <= do_step && (phase == PH_IMAG);
        end
    end

    assign addr       = ptr_q;
    assign imag_phase = (phase == PH_IMAG);
endmodule

// File: rtl/cra_agen_chk.sv
// Property checker for cplx_ring_agen, attached by bind below.
// Observes ports plus the decoded window mask.
module cra_agen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_en,
    input logic [ADDR_W-1:0] load_addr,
    input logic              step,
    input logic [ADDR_W-1:0] addr,
    input logic              imag_phase,
    input logic              elem_done,
    input logic              align_err,
    input logic [ADDR_W-1:0] win_mask
);
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !step) |=> $stable(addr)); // R10
    AST_NO_ODD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        addr[0] == 1'b0); // R3
    AST_ALIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (align_err == ($past(load_addr[1:0]) != 2'b00))); // R3
    AST_UPPER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_en) |=> ((addr & ~$past(win_mask)) == ($past(addr) & ~$past(win_mask)))); // R5
    AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_en) |=> (imag_phase != $past(imag_phase))); // R7
    AST_ELEM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_en && imag_phase) |=> elem_done); // R8
    AST_ELEM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && !load_en && imag_phase) |=> !elem_done); // R8
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (addr == ($past(load_addr) & ~ADDR_W'(3)))); // R9
endmodule

bind cplx_ring_agen cra_agen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .load_addr  (load_addr),
    .step       (step),
    .addr       (addr),
    .imag_phase (imag_phase),
    .elem_done  (elem_done),
    .align_err  (align_err),
    .win_mask   (win_mask)
);

// File: tb/cplx_ring_agen_test.sv
// Directed bench for cplx_ring_agen: one task per scenario.
module cplx_ring_agen_test;
    localparam int AW = 32;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [SW-1:0] size_code = '0;
    logic          step = 1'b0;
    logic [AW-1:0] addr;
    logic          imag_phase;
    logic          elem_done;
    logic          align_err;

    int n_chk = 0;
    int n_err = 0;

    cplx_ring_agen #(.ADDR_W(AW), .SIZE_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .size_code(size_code), .step(step), .addr(addr),
        .imag_phase(imag_phase), .elem_done(elem_done), .align_err(align_err)
    );

    always #2 clk = ~clk;  // 250 MHz

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive a load at a negedge; results visible at the following negedge
    task automatic do_load(input logic [AW-1:0] a);
        @(negedge clk);
        load_en = 1'b1; load_addr = a;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic do_step();
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    // independent model of a wrapped step
    function automatic logic [AW-1:0] model_step(input logic [AW-1:0] p, input int k);
        longint unsigned w, base, off;
        w    = 64'd1 << (k + 2);
        base = longint'(p) - (longint'(p) % w);
        off  = ((longint'(p) % w) + 2) % w;
        return AW'(base + off);
    endfunction

    task automatic t_reset();
        chk("R1 addr", addr, '0);
        chk("R1 imag", AW'(imag_phase), '0);
        chk("R1 elem", AW'(elem_done), '0);
        chk("R1 align", AW'(align_err), '0);
    endtask

    task automatic t_load_aligned();
        do_load(32'h0000_1234 & ~32'h3);
        chk("R2 addr", addr, 32'h0000_1234);
        chk("R2 align", AW'(align_err), 0);
    endtask

    task automatic t_load_unaligned();
        do_load(32'h0000_0103);
        chk("R3 addr", addr, 32'h0000_0100);
        chk("R3 align", AW'(align_err), 1);
        do_load(32'h0000_0200);
        chk("R2 align cleared", AW'(align_err), 0);
    endtask

    // walk a full buffer and beyond for size code k
    task automatic t_walk(input int k, input logic [AW-1:0] start, input int steps);
        logic [AW-1:0] exp_a;
        logic          was_imag;
        size_code = SW'(k);
        do_load(start);
        exp_a = start;
        for (int i = 0; i < steps; i++) begin
            was_imag = exp_a[1];
            chk("R7 phase", AW'(imag_phase), AW'(exp_a[1]));
            do_step();
            exp_a = model_step(exp_a, k);
            chk($sformatf("R4/R5/R6 k=%0d step %0d", k, i), addr, exp_a);
            chk("R8 strobe", AW'(elem_done), AW'(was_imag));
        end
    endtask

    task automatic t_collide();
        size_code = 4'd1;
        do_load(32'h0000_0010);
        do_step();
        chk("R9 pre imag", AW'(imag_phase), 1);
        @(negedge clk);
        load_en = 1'b1; step = 1'b1; load_addr = 32'h0000_0040;
        @(negedge clk);
        load_en = 1'b0; step = 1'b0;
        chk("R9 addr", addr, 32'h0000_0040);
        chk("R9 no strobe", AW'(elem_done), 0);
        chk("R9 real", AW'(imag_phase), 0);
    endtask

    task automatic t_hold();
        logic [AW-1:0] keep;
        keep = addr;
        repeat (3) @(negedge clk);
        chk("R10 hold", addr, keep);
        chk("R10 no strobe", AW'(elem_done), 0);
    endtask

    initial begin : watchdog
        #(4 * 20000);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_aligned();
        t_load_unaligned();
        t_walk(0, 32'h0000_0020, 4);        // R6: 4-byte buffer
        t_walk(1, 32'h1000_0A08, 6);        // R5: 8-byte wrap, upper bits kept
        t_walk(3, 32'hABCD_007C, 4);        // R6: 32-byte buffer, start near end
        t_collide();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule